// File: doc/BRIEF.md
# Scalar Memory Issue and Return Controller

This block sits between the stage that issues scalar memory instructions and the memory port. Requests (load, store, atomic with or without returned data) are queued in order in an issue FIFO and launched toward memory one per cycle. Two independent in-flight counters limit how many read-type and write-type requests may be outstanding at once. Atomics are counted as reads.

Memory responses come back tagged with their operation, their wavefront ID and a latency delay. Read-type responses are placed in a return-read FIFO and stores in a return-write FIFO. At most one response retires per cycle toward the scalar register file. The read FIFO always has precedence. Retirement waits for three things: the response's delay to expire, the shared writeback bus to be idle, and, for responses that write a register, the register file to accept the write. Each retirement updates per-wavefront outstanding counters, and those counters are published as status vectors. The wait logic of the wavefronts reads these vectors.

Top module: `smem_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_valid`, `ret_valid`, `cand_valid` and `err_underflow` are 0, and every per-wave counter reads 0.
- R2: Operation codes are 0 = load, 1 = store, 2 = atomic returning data, 3 = atomic without return data. A request accepted at a clock edge (`req_valid` and `req_ready`) is presented on `mem_valid`/`mem_op`/`mem_wave` in the next cycle if it is not throttled. Requests launch strictly in acceptance order.
- R3: The head request does not launch while its class counter equals QSIZE. Loads and both atomic kinds form one class and stores the other. A stalled head blocks all requests behind it.
- R4: When a class counter sees a launch and a retirement in the same cycle, its value is unchanged. Issue and retirement may both happen in one cycle.
- R5: At most one response retires per cycle. Whenever the return-read FIFO is non-empty its head is the only candidate, even if that head is not yet ready.
- R6: A response captured at a clock edge with delay d may retire no earlier than the cycle that begins d clock edges after the capture edge.
- R7: Loads and returning atomics retire only while `srf_ok` is 1, and they retire with `ret_wb` = 1. Stores and non-returning atomics ignore `srf_ok` and retire with `ret_wb` = 0.
- R8: After a retirement, no retirement occurs in the next BUS_BUSY cycles.
- R9: Each accepted request increments its wave's total and wait counters. It also increments the read counter for codes 0/2/3 and the write counter for codes 1/2/3. Each retirement decrements the same set. Changes appear in the cycle after the edge.
- R10: A retirement whose class counter is already 0 sets the sticky `err_underflow` flag, and the counter stays at 0.
- R11: `req_ready` is 0 while the issue FIFO holds IQ_DEPTH requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | New request offered |
| req_op | input | 2 | Request operation code |
| req_wave | input | WID_W | Request wavefront ID |
| req_ready | output | 1 | Issue FIFO has room |
| mem_valid | output | 1 | Request launched to memory this cycle |
| mem_op | output | 2 | Launched operation code |
| mem_wave | output | WID_W | Launched wavefront ID |
| rsp_valid | input | 1 | Memory response arriving |
| rsp_op | input | 2 | Response operation code |
| rsp_wave | input | WID_W | Response wavefront ID |
| rsp_delay | input | DLY_W | Cycles before the response may retire |
| cand_valid | output | 1 | A retire candidate exists |
| cand_wave | output | WID_W | Candidate wavefront ID |
| cand_wb | output | 1 | Candidate needs a register write |
| srf_ok | input | 1 | Register file accepts the candidate's write |
| ret_valid | output | 1 | Response retires this cycle |
| ret_op | output | 2 | Retiring operation code |
| ret_wave | output | WID_W | Retiring wavefront ID |
| ret_wb | output | 1 | Retiring response writes a register |
| wave_total | output | NUM_WAVES*CNT_W | Per-wave outstanding requests |
| wave_rd | output | NUM_WAVES*CNT_W | Per-wave outstanding global reads |
| wave_wr | output | NUM_WAVES*CNT_W | Per-wave outstanding global writes |
| wave_lgkm | output | NUM_WAVES*CNT_W | Per-wave outstanding scalar memory instructions |
| err_underflow | output | 1 | Sticky retire-without-in-flight flag |

## Verification
A wrong class counter shows up within one cycle as a launch that comes too early or a head that stalls for too long, and the effect is visible on `mem_valid`. A drifting per-wave counter shows up on the status vectors in the cycle after the faulty event, and it is still wrong once all traffic has drained. A wrong delay countdown or a wrong bus timer moves the `ret_valid` pulse by whole cycles. A broken priority decision changes the order of `ret_op` values when a store is ready behind a read that is not.

// File: rtl/smem_pkg.sv
// Shared operation encoding and classification helpers for the scalar
// memory controller. Assumes a 2-bit operation code on every interface.
package smem_pkg;

    typedef enum logic [1:0] {
        SOP_LOAD     = 2'd0,
        SOP_STORE    = 2'd1,
        SOP_ATOM_RET = 2'd2,
        SOP_ATOM_NR  = 2'd3
    } smem_op_e;

    // Read class: loads and every atomic
    function automatic logic op_is_read(input smem_op_e op);
        return op != SOP_STORE;
    endfunction

    // Write class: stores and every atomic
    function automatic logic op_is_write(input smem_op_e op);
        return op != SOP_LOAD;
    endfunction

    // Needs a destination register write at retirement
    function automatic logic op_needs_wb(input smem_op_e op);
        return (op == SOP_LOAD) || (op == SOP_ATOM_RET);
    endfunction

endpackage

// File: rtl/smem_fifo.sv
// In-order FIFO with a per-entry countdown. Each entry is loaded with a
// delay at push and counts down to zero, one step per cycle; the head is
// ready once its count is zero. Assumes no push while full unless popping.
module smem_fifo #(
    parameter int W     = 4,
    parameter int DEPTH = 4,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic [DLY_W-1:0] push_dly,
    input  logic             pop,
    output logic [W-1:0]     head_data,
    output logic             head_ready,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW    = $clog2(DEPTH + 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [DLY_W-1:0] dly_q [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);

    assign head_data  = mem_q[rd_q];
    assign head_ready = (dly_q[rd_q] == '0);

    // Pointer wrap helper
    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= nxt(wr_q);
            if (do_pop)  rd_q <= nxt(rd_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_slot
            // Payload capture for this slot
            always_ff @(posedge clk) begin
                if (do_push && wr_q == PTR_W'(gi)) mem_q[gi] <= push_data;
            end
            // Delay countdown for this slot
            always_ff @(posedge clk) begin
                if (!rst_n)                             dly_q[gi] <= '0;
                else if (do_push && wr_q == PTR_W'(gi)) dly_q[gi] <= push_dly;
                else if (dly_q[gi] != '0)               dly_q[gi] <= dly_q[gi] - 1'b1;
            end
        end
    endgenerate

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(cnt_q));
    a_r11_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/smem_issue.sv
// Issue throttle. Holds one in-flight counter for the read class
// (loads, atomics) and one for stores, and launches the issue-FIFO head
// when its class counter is below QSIZE. Retirements decrement the
// matching counter; a retirement against zero sets a sticky error flag.
module smem_issue
    import smem_pkg::*;
#(
    parameter int QSIZE = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     head_valid,
    input  logic     head_ready,
    input  smem_op_e head_op,
    input  logic     dec_rd,
    input  logic     dec_st,
    output logic     launch,
    output logic     err
);
    localparam int IC_W = $clog2(QSIZE + 1);

    logic [IC_W-1:0] rd_cnt_q, st_cnt_q;
    logic            head_rd, inc_rd, inc_st;

    assign head_rd = op_is_read(head_op);
    assign launch  = head_valid && head_ready &&
                     (head_rd ? (rd_cnt_q < IC_W'(QSIZE)) : (st_cnt_q < IC_W'(QSIZE)));
    assign inc_rd  = launch && head_rd;
    assign inc_st  = launch && !head_rd;

    // Counter step: +1, -1 (never below zero), or hold when both
    function automatic logic [IC_W-1:0] step(input logic [IC_W-1:0] c,
                                             input logic up, input logic dn);
        logic dn_ok;
        dn_ok = dn && (c != '0);
        if (up && !dn_ok) return c + 1'b1;
        if (dn_ok && !up) return c - 1'b1;
        return c;
    endfunction

    // In-flight counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt_q <= '0;
            st_cnt_q <= '0;
        end else begin
            rd_cnt_q <= step(rd_cnt_q, inc_rd, dec_rd);
            st_cnt_q <= step(st_cnt_q, inc_st, dec_st);
        end
    end

    // Sticky underflow flag
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else if ((dec_rd && rd_cnt_q == '0) || (dec_st && st_cnt_q == '0)) err <= 1'b1;
    end

    a_r3_rd_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt_q <= IC_W'(QSIZE));
    a_r3_st_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_cnt_q <= IC_W'(QSIZE));
    a_r4_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_rd && dec_rd && rd_cnt_q != '0) |=> $stable(rd_cnt_q));
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    a_r10_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_st && !inc_st && st_cnt_q == '0) |=> st_cnt_q == '0);

endmodule

// File: rtl/smem_retire.sv
// Retire arbiter. The read-FIFO head is the sole candidate whenever that
// FIFO is non-empty; otherwise the store-FIFO head is. The candidate fires
// when its delay has expired, the writeback bus timer is idle and, for
// register-writing ops, the register file accepts. A fire holds the bus
// for BUS_BUSY further cycles.
module smem_retire
    import smem_pkg::*;
#(
    parameter int BUS_BUSY = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rd_empty,
    input  logic     rd_ready,
    input  smem_op_e rd_op,
    input  logic     st_empty,
    input  logic     st_ready,
    input  smem_op_e st_op,
    input  logic     srf_ok,
    output logic     cand_valid,
    output logic     sel_rd,
    output logic     cand_wb,
    output logic     pop_rd,
    output logic     pop_st
);
    localparam int BT_W = (BUS_BUSY > 0) ? $clog2(BUS_BUSY + 1) : 1;

    logic [BT_W-1:0] bus_q;
    logic            cand_ready, fire;

    assign sel_rd     = !rd_empty;
    assign cand_valid = !rd_empty || !st_empty;
    assign cand_ready = sel_rd ? rd_ready : st_ready;
    assign cand_wb    = sel_rd ? op_needs_wb(rd_op) : op_needs_wb(st_op);
    assign fire       = cand_valid && cand_ready && (bus_q == '0) &&
                        (!cand_wb || srf_ok);
    assign pop_rd     = fire && sel_rd;
    assign pop_st     = fire && !sel_rd;

    // Writeback bus occupancy timer
    always_ff @(posedge clk) begin
        if (!rst_n)             bus_q <= '0;
        else if (fire)          bus_q <= BT_W'(BUS_BUSY);
        else if (bus_q != '0)   bus_q <= bus_q - 1'b1;
    end

    a_r5_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pop_rd, pop_st}));
    a_r5_rd_first: assert property (@(posedge clk) disable iff (!rst_n)
        pop_st |-> rd_empty);
    a_r7_srf_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ((pop_rd || pop_st) && cand_wb) |-> srf_ok);

    generate
        if (BUS_BUSY > 0) begin : g_gap
            a_r8_gap: assert property (@(posedge clk) disable iff (!rst_n)
                (pop_rd || pop_st) |=> !(pop_rd || pop_st));
        end
    endgenerate

endmodule

// File: rtl/smem_wave_cnt.sv
// Per-wavefront outstanding counters: total, global reads, global writes
// and the scalar-memory wait count. Accepted requests increment; retired
// responses decrement. Counters saturate at both ends.
module smem_wave_cnt
    import smem_pkg::*;
#(
    parameter int NUM_WAVES = 4,
    parameter int WID_W     = 2,
    parameter int CNT_W     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       acc,
    input  smem_op_e                   acc_op,
    input  logic [WID_W-1:0]           acc_wave,
    input  logic                       ret,
    input  smem_op_e                   ret_op,
    input  logic [WID_W-1:0]           ret_wave,
    output logic [NUM_WAVES*CNT_W-1:0] total_o,
    output logic [NUM_WAVES*CNT_W-1:0] rd_o,
    output logic [NUM_WAVES*CNT_W-1:0] wr_o,
    output logic [NUM_WAVES*CNT_W-1:0] lgkm_o
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    // Saturating up/down step
    function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c,
                                              input logic up, input logic dn);
        if (up && !dn) return (c == CMAX) ? c : c + 1'b1;
        if (dn && !up) return (c == '0) ? c : c - 1'b1;
        return c;
    endfunction

    genvar gw;
    generate
        for (gw = 0; gw < NUM_WAVES; gw++) begin : g_wave
            logic             hit_a, hit_r;
            logic [CNT_W-1:0] tot_q, rd_q, wr_q, lg_q;

            assign hit_a = acc && (acc_wave == WID_W'(gw));
            assign hit_r = ret && (ret_wave == WID_W'(gw));

            // Four counters of this wavefront
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tot_q <= '0;
                    rd_q  <= '0;
                    wr_q  <= '0;
                    lg_q  <= '0;
                end else begin
                    tot_q <= bump(tot_q, hit_a, hit_r);
                    lg_q  <= bump(lg_q,  hit_a, hit_r);
                    rd_q  <= bump(rd_q,  hit_a && op_is_read(acc_op),  hit_r && op_is_read(ret_op));
                    wr_q  <= bump(wr_q,  hit_a && op_is_write(acc_op), hit_r && op_is_write(ret_op));
                end
            end

            assign total_o[gw*CNT_W +: CNT_W] = tot_q;
            assign rd_o[gw*CNT_W +: CNT_W]    = rd_q;
            assign wr_o[gw*CNT_W +: CNT_W]    = wr_q;
            assign lgkm_o[gw*CNT_W +: CNT_W]  = lg_q;

            a_r9_rd_le_total: assert property (@(posedge clk) disable iff (!rst_n)
                (tot_q != CMAX) |-> (rd_q <= tot_q));
        end
    endgenerate

endmodule

// File: rtl/smem_ctrl.sv
// Scalar memory issue and return controller (top). Queues requests,
// throttles launches per class, collects responses into read/store return
// FIFOs, retires one per cycle toward the register file and keeps the
// per-wave outstanding counters. Assumes memory accepts every launch and
// returns at most one response per launched request.
module smem_ctrl
    import smem_pkg::*;
#(
    parameter int NUM_WAVES = 4,
    parameter int WID_W     = $clog2(NUM_WAVES),
    parameter int QSIZE     = 2,
    parameter int IQ_DEPTH  = 4,
    parameter int DLY_W     = 4,
    parameter int BUS_BUSY  = 2,
    parameter int CNT_W     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [1:0]                 req_op,
    input  logic [WID_W-1:0]           req_wave,
    output logic                       req_ready,
    output logic                       mem_valid,
    output logic [1:0]                 mem_op,
    output logic [WID_W-1:0]           mem_wave,
    input  logic                       rsp_valid,
    input  logic [1:0]                 rsp_op,
    input  logic [WID_W-1:0]           rsp_wave,
    input  logic [DLY_W-1:0]           rsp_delay,
    output logic                       cand_valid,
    output logic [WID_W-1:0]           cand_wave,
    output logic                       cand_wb,
    input  logic                       srf_ok,
    output logic                       ret_valid,
    output logic [1:0]                 ret_op,
    output logic [WID_W-1:0]           ret_wave,
    output logic                       ret_wb,
    output logic [NUM_WAVES*CNT_W-1:0] wave_total,
    output logic [NUM_WAVES*CNT_W-1:0] wave_rd,
    output logic [NUM_WAVES*CNT_W-1:0] wave_wr,
    output logic [NUM_WAVES*CNT_W-1:0] wave_lgkm,
    output logic                       err_underflow
);
    localparam int PW = 2 + WID_W;

    logic          acc, launch;
    logic [PW-1:0] iq_head, rq_head, sq_head, sel_head;
    logic          iq_ready, iq_empty, iq_full;
    logic          rq_ready, rq_empty, rq_full;
    logic          sq_ready, sq_empty, sq_full;
    logic          rsp_rd, sel_rd, pop_rd, pop_st;
    smem_op_e      iq_op, rq_op, sq_op, rsp_op_e;

    assign acc       = req_valid && req_ready;
    assign req_ready = !iq_full;
    assign rsp_op_e  = smem_op_e'(rsp_op);
    assign rsp_rd    = op_is_read(rsp_op_e);

    // Issue FIFO: in-order request queue, no delay
    smem_fifo #(.W(PW), .DEPTH(IQ_DEPTH), .DLY_W(DLY_W)) u_iq (
        .clk(clk), .rst_n(rst_n),
        .push(acc), .push_data({req_op, req_wave}), .push_dly('0),
        .pop(launch), .head_data(iq_head), .head_ready(iq_ready),
        .empty(iq_empty), .full(iq_full)
    );

    assign iq_op = smem_op_e'(iq_head[PW-1 -: 2]);

    // Launch throttle and in-flight counters
    smem_issue #(.QSIZE(QSIZE)) u_issue (
        .clk(clk), .rst_n(rst_n),
        .head_valid(!iq_empty), .head_ready(iq_ready), .head_op(iq_op),
        .dec_rd(pop_rd), .dec_st(pop_st),
        .launch(launch), .err(err_underflow)
    );

    assign mem_valid = launch;
    assign mem_op    = iq_head[PW-1 -: 2];
    assign mem_wave  = iq_head[WID_W-1:0];

    // Return FIFOs: read class and stores
    smem_fifo #(.W(PW), .DEPTH(QSIZE), .DLY_W(DLY_W)) u_rq (
        .clk(clk), .rst_n(rst_n),
        .push(rsp_valid && rsp_rd), .push_data({rsp_op, rsp_wave}), .push_dly(rsp_delay),
        .pop(pop_rd), .head_data(rq_head), .head_ready(rq_ready),
        .empty(rq_empty), .full(rq_full)
    );

    smem_fifo #(.W(PW), .DEPTH(QSIZE), .DLY_W(DLY_W)) u_sq (
        .clk(clk), .rst_n(rst_n),
        .push(rsp_valid && !rsp_rd), .push_data({rsp_op, rsp_wave}), .push_dly(rsp_delay),
        .pop(pop_st), .head_data(sq_head), .head_ready(sq_ready),
        .empty(sq_empty), .full(sq_full)
    );

    assign rq_op = smem_op_e'(rq_head[PW-1 -: 2]);
    assign sq_op = smem_op_e'(sq_head[PW-1 -: 2]);

    // Retire arbitration and writeback gating
    smem_retire #(.BUS_BUSY(BUS_BUSY)) u_ret (
        .clk(clk), .rst_n(rst_n),
        .rd_empty(rq_empty), .rd_ready(rq_ready), .rd_op(rq_op),
        .st_empty(sq_empty), .st_ready(sq_ready), .st_op(sq_op),
        .srf_ok(srf_ok),
        .cand_valid(cand_valid), .sel_rd(sel_rd), .cand_wb(cand_wb),
        .pop_rd(pop_rd), .pop_st(pop_st)
    );

    assign sel_head  = sel_rd ? rq_head : sq_head;
    assign cand_wave = sel_head[WID_W-1:0];
    assign ret_valid = pop_rd || pop_st;
    assign ret_op    = sel_head[PW-1 -: 2];
    assign ret_wave  = sel_head[WID_W-1:0];
    assign ret_wb    = cand_wb;

    // Per-wave outstanding counters
    smem_wave_cnt #(.NUM_WAVES(NUM_WAVES), .WID_W(WID_W), .CNT_W(CNT_W)) u_wave (
        .clk(clk), .rst_n(rst_n),
        .acc(acc), .acc_op(smem_op_e'(req_op)), .acc_wave(req_wave),
        .ret(ret_valid), .ret_op(smem_op_e'(ret_op)), .ret_wave(ret_wave),
        .total_o(wave_total), .rd_o(wave_rd), .wr_o(wave_wr), .lgkm_o(wave_lgkm)
    );

    a_r3_rq_room: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_rd) |-> (!rq_full || pop_rd));
    a_r3_sq_room: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_rd) |-> (!sq_full || pop_st));
    a_r2_launch_src: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !iq_empty);

endmodule

// File: tb/test_smem_ctrl.sv
module test_smem_ctrl;
    localparam int NW = 4, WW = 2, CW = 4, DW = 4;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          req_valid = 1'b0, rsp_valid = 1'b0, srf_ok = 1'b1;
    logic [1:0]    req_op = '0, rsp_op = '0;
    logic [WW-1:0] req_wave = '0, rsp_wave = '0;
    logic [DW-1:0] rsp_delay = '0;
    logic          req_ready, mem_valid, cand_valid, cand_wb, ret_valid, ret_wb, err_underflow;
    logic [1:0]    mem_op, ret_op;
    logic [WW-1:0] mem_wave, cand_wave, ret_wave;
    logic [NW*CW-1:0] wave_total, wave_rd, wave_wr, wave_lgkm;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    smem_ctrl i_smem_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_wave(req_wave), .req_ready(req_ready),
        .mem_valid(mem_valid), .mem_op(mem_op), .mem_wave(mem_wave),
        .rsp_valid(rsp_valid), .rsp_op(rsp_op), .rsp_wave(rsp_wave), .rsp_delay(rsp_delay),
        .cand_valid(cand_valid), .cand_wave(cand_wave), .cand_wb(cand_wb), .srf_ok(srf_ok),
        .ret_valid(ret_valid), .ret_op(ret_op), .ret_wave(ret_wave), .ret_wb(ret_wb),
        .wave_total(wave_total), .wave_rd(wave_rd), .wave_wr(wave_wr), .wave_lgkm(wave_lgkm),
        .err_underflow(err_underflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int wv(input logic [NW*CW-1:0] v, input int w);
        return int'(v[w*CW +: CW]);
    endfunction

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_valid = 1'b0; rsp_valid = 1'b0; srf_ok = 1'b1;
        repeat (3) nxt();
        rst_n = 1'b1;
        nxt(); #1;
        // R1 reset state
        chk("R1 req_ready", int'(req_ready), 1);
        chk("R1 mem_valid", int'(mem_valid), 0);
        chk("R1 ret_valid", int'(ret_valid), 0);
        chk("R1 cand_valid", int'(cand_valid), 0);
        chk("R1 err", int'(err_underflow), 0);
        chk("R1 counters", int'(|{wave_total, wave_rd, wave_wr, wave_lgkm}), 0);
    endtask

    task automatic put_req(input int op, input int w);
        req_valid = 1'b1; req_op = 2'(op); req_wave = WW'(w);
    endtask

    task automatic put_rsp(input int op, input int w, input int d);
        rsp_valid = 1'b1; rsp_op = 2'(op); rsp_wave = WW'(w); rsp_delay = DW'(d);
    endtask

    initial begin
        do_reset();

        // Sweep over every wave and op: launch, counters, delay, retire
        for (int w = 0; w < NW; w++) begin
            for (int o = 0; o < 4; o++) begin
                int d;
                int erd, ewr;
                d = (w + o) % 3;
                erd = (o != 1) ? 1 : 0;
                ewr = (o != 0) ? 1 : 0;
                put_req(o, w);
                nxt(); req_valid = 1'b0; #1;
                chk("R2 launch", int'(mem_valid), 1);
                chk("R2 mem_op", int'(mem_op), o);
                chk("R2 mem_wave", int'(mem_wave), w);
                chk("R9 total", wv(wave_total, w), 1);
                chk("R9 lgkm", wv(wave_lgkm, w), 1);
                chk("R9 rd", wv(wave_rd, w), erd);
                chk("R9 wr", wv(wave_wr, w), ewr);
                nxt(); #1;
                chk("R2 single launch", int'(mem_valid), 0);
                put_rsp(o, w, d);
                nxt(); rsp_valid = 1'b0;
                for (int k = 1; k <= d + 2; k++) begin
                    #1;
                    chk("R6 retire cycle", int'(ret_valid), (k == d + 1) ? 1 : 0);
                    if (k == d + 1) begin
                        chk("R6 ret_op", int'(ret_op), o);
                        chk("R6 ret_wave", int'(ret_wave), w);
                        chk("R7 ret_wb", int'(ret_wb), (o == 0 || o == 2) ? 1 : 0);
                    end
                    nxt();
                end
                #1;
                chk("R9 total back", wv(wave_total, w), 0);
                chk("R9 rd back", wv(wave_rd, w), 0);
                chk("R9 wr back", wv(wave_wr, w), 0);
                chk("R9 lgkm back", wv(wave_lgkm, w), 0);
            end
        end

        // Register file gating
        do_reset();
        put_req(1, 1); nxt();
        put_req(3, 1); nxt();
        put_req(0, 2); nxt();
        req_valid = 1'b0; repeat (2) nxt();
        srf_ok = 1'b0;
        put_rsp(1, 1, 0); nxt(); rsp_valid = 1'b0; #1;
        chk("R7 store ignores srf_ok", int'(ret_valid), 1);
        chk("R7 store wb", int'(ret_wb), 0);
        repeat (3) nxt();
        put_rsp(3, 1, 0); nxt(); rsp_valid = 1'b0; #1;
        chk("R7 nr-atomic ignores srf_ok", int'(ret_valid), 1);
        repeat (3) nxt();
        put_rsp(0, 2, 0); nxt(); rsp_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            #1;
            chk("R7 load held", int'(ret_valid), 0);
            chk("R7 cand_wb", int'(cand_wb), 1);
            chk("R7 cand_wave", int'(cand_wave), 2);
            nxt();
        end
        srf_ok = 1'b1; #1;
        chk("R7 load released", int'(ret_valid), 1);
        nxt(); #1;
        chk("R9 wave2 drained", wv(wave_total, 2), 0);
        chk("R9 wave1 wr drained", wv(wave_wr, 1), 0);

        // Read priority, delay and bus gap
        do_reset();
        put_req(0, 0); nxt();
        put_req(1, 1); nxt();
        req_valid = 1'b0; repeat (2) nxt();
        put_rsp(0, 0, 5); nxt();
        for (int k = 1; k <= 10; k++) begin
            if (k == 1) put_rsp(1, 1, 0);
            else rsp_valid = 1'b0;
            #1;
            chk("R5 R8 retire pattern", int'(ret_valid), (k == 6 || k == 9) ? 1 : 0);
            if (k >= 2 && k <= 5) chk("R5 read head favoured", int'(cand_wave), 0);
            if (k == 6) chk("R5 load first", int'(ret_op), 0);
            if (k == 9) chk("R8 store after gap", int'(ret_op), 1);
            nxt();
        end

        // Throttle, same-cycle update, FIFO full
        do_reset();
        put_req(0, 0); nxt(); req_valid = 1'b0; #1;
        chk("R2 L1 launch", int'(mem_valid), 1);
        nxt();
        put_rsp(0, 0, 0); put_req(2, 0); nxt();
        rsp_valid = 1'b0; req_valid = 1'b0; #1;
        chk("R4 retire same cycle", int'(ret_valid), 1);
        chk("R4 launch same cycle", int'(mem_valid), 1);
        nxt();
        put_req(0, 0); nxt();
        put_req(3, 0); #1;
        chk("R4 count held, L3 launches", int'(mem_valid), 1);
        nxt();
        put_req(1, 3); #1;
        chk("R3 atomic stalls at cap", int'(mem_valid), 0);
        nxt(); put_req(1, 3); nxt(); put_req(1, 3); nxt();
        req_valid = 1'b0; #1;
        chk("R11 fifo full", int'(req_ready), 0);
        chk("R3 stores blocked behind head", int'(mem_valid), 0);
        put_rsp(2, 0, 0); nxt(); rsp_valid = 1'b0; #1;
        chk("R5 atomic retires", int'(ret_valid), 1);
        chk("R5 atomic op", int'(ret_op), 2);
        nxt(); #1;
        chk("R3 released atomic launches", int'(mem_valid), 1);
        chk("R3 released op", int'(mem_op), 3);
        nxt(); #1;
        chk("R3 store launches", int'(mem_valid), 1);
        chk("R11 room again", int'(req_ready), 1);
        nxt(); #1;
        chk("R3 second store launches", int'(mem_valid), 1);
        nxt(); #1;
        chk("R3 store cap", int'(mem_valid), 0);
        chk("R9 wave0 total", wv(wave_total, 0), 2);
        chk("R9 wave3 wr", wv(wave_wr, 3), 3);

        // Underflow flag
        do_reset();
        put_rsp(1, 3, 0); nxt(); rsp_valid = 1'b0; #1;
        chk("R10 retire without launch", int'(ret_valid), 1);
        chk("R10 flag clear before edge", int'(err_underflow), 0);
        nxt(); #1;
        chk("R10 flag set", int'(err_underflow), 1);
        chk("R10 wave counter floor", wv(wave_total, 3), 0);
        repeat (3) nxt(); #1;
        chk("R10 flag sticky", int'(err_underflow), 1);
        put_req(1, 3); nxt(); req_valid = 1'b0; #1;
        chk("R10 store counter still zero", int'(mem_valid), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule